// File: doc/BRIEF.md
# Serial Bus PHY Control Packet Responder

This block sits behind the receive decoder of a serial bus physical layer and reacts to the small control packets that other nodes address to it. Each control packet arrives as a 32-bit quadlet followed by its bitwise inverse. The block checks that pairing and compares the target node field with the local node number. It then acts on the packet: it raises a sticky link-on flag, answers a ping with the node's self-identification quadlets, answers a register read with a reply quadlet, or carries out a remote command on its per-port enable and suspend state and then confirms it. A resume packet clears every suspend bit and sends no answer.

Replies leave on a valid/ready stream. Every reply quadlet is sent first as is and then inverted. Only one reply can be outstanding at a time. A request that arrives while a reply is still being sent is dropped, and a saturating counter records it. The self-ID content comes in as ready-made words. The register file is read through a combinational address/data port.

Top module: `phy_ctl_responder`

## Requirements
- R1: A packet is accepted only when the quadlet received after it equals its exact bitwise inverse. Otherwise both quadlets are discarded with no effect, and the next received quadlet starts a new pair.
- R2: The target node field is bits [29:24]. A packet acts only when that field equals `node_id` and the field is not 63. Any other target causes no reply and no state change.
- R3: A link-on packet (bits [31:30] = 01) that targets this node sets `link_on`, which then stays set until reset.
- R4: An extended packet (bits [31:30] = 00) with subtype bits [21:18] = 0 is a ping. It is answered with the NSELF words of `selfid_words`, word i taken from bits [32i+31:32i], sent in order. In word 0, bits [7:0] are replaced by the number of clock cycles that the first reply quadlet was held valid without `reply_ready`, saturating at 255.
- R5: Subtype 1 is a register read of index bits [17:14], presented on `reg_addr`. The reply is {2'b00, node_id, 2'b00, 4'd3, index, 6'd0, reg_data}.
- R6: Subtype 8 is a remote command. The port is in bits [17:14] and the operation in bits [2:0]: 0 disables the port, 1 enables it, 2 suspends it, 3 un-suspends it, and 4 clears the fault flag. The new state is visible on the cycle after the packet is accepted.
- R7: A command whose port is not below NPORTS, or whose operation is 5 to 7, changes no port state or fault state. It is still confirmed, with the fault bit set.
- R8: A command is confirmed with {2'b00, node_id, 2'b00, 4'd10, port, 10'd0, fault_bit, op}.
- R9: Subtype 15 (resume) clears every suspend bit, even while a reply is pending, and produces no reply.
- R10: Each reply quadlet is followed directly by its bitwise inverse. A quadlet is held on `reply_quadlet` with `reply_valid` high until `reply_ready` is seen.
- R11: A ping, read or command that arrives while `reply_valid` is high is dropped. It gets no reply and causes no state change, and `drop_count` rises by one, saturating at 255.
- R12: After reset, `link_on` is 0, all ports are enabled, none is suspended, `fault` is 0, `drop_count` is 0 and `reply_valid` is 0.
- R13: A high `fault_set` sets `fault` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| node_id | input | 6 | Local node number |
| rx_valid | input | 1 | A received quadlet is present |
| rx_quadlet | input | 32 | Received quadlet |
| selfid_words | input | NSELF*32 | Self-ID words sent in answer to a ping |
| reg_addr | output | 4 | Register file read index |
| reg_data | input | 8 | Register file read data (combinational) |
| fault_set | input | 1 | Sets the fault flag |
| reply_valid | output | 1 | A reply quadlet is present |
| reply_ready | input | 1 | The consumer takes the reply quadlet |
| reply_quadlet | output | 32 | Reply quadlet |
| link_on | output | 1 | Sticky link-on state |
| port_en | output | NPORTS | Per-port enable |
| port_susp | output | NPORTS | Per-port suspend |
| fault | output | 1 | Fault flag |
| drop_count | output | 8 | Saturating count of dropped requests |

## Verification
Link-on packets are swept over every target value with a fixed node number, and again with the node number set to 63. This separates a true match from a near miss and from the broadcast value. Remote commands are swept over all sixteen port codes and all eight operation codes against an arithmetic model of the port state. This separates legal commands from out-of-range ports and unused operations, both in the confirmation's fault bit and in the unchanged state. Ping replies are taken with no stall, a short stall and a stall long enough to saturate, which shows whether the response-time field counts and clamps. Corrupted complements, requests sent while a reply is pending, and a resume sent during a pending reply show apart the paths that drop a request, discard it, or act on it without answering.

// File: rtl/phy_ctl_pkg.sv
// Shared field positions, codes and widths for the PHY control responder.
// Assumes 32-bit quadlets and a 6-bit node number.
package phy_ctl_pkg;
    localparam int QW       = 32;
    localparam int NODE_W   = 6;
    localparam logic [NODE_W-1:0] NODE_BCAST = 6'd63;

    localparam logic [1:0] KIND_EXT  = 2'b00;
    localparam logic [1:0] KIND_LINK = 2'b01;

    localparam logic [3:0] SUB_PING    = 4'd0;
    localparam logic [3:0] SUB_READ    = 4'd1;
    localparam logic [3:0] SUB_CMD     = 4'd8;
    localparam logic [3:0] SUB_RESUME  = 4'd15;
    localparam logic [3:0] SUB_RDREPLY = 4'd3;
    localparam logic [3:0] SUB_CONFIRM = 4'd10;

    typedef enum logic [2:0] {
        OP_PORT_OFF  = 3'd0,
        OP_PORT_ON   = 3'd1,
        OP_SUSP_ON   = 3'd2,
        OP_SUSP_OFF  = 3'd3,
        OP_CLR_FAULT = 3'd4
    } op_e;

    localparam logic [2:0] OP_LAST = 3'd4;
endpackage

// File: rtl/phy_rx_pair.sv
// Pairs received quadlets: the first one is held, and the second must be its
// exact inverse. A good pair yields a one-cycle strobe with the held quadlet.
// Assumes at most one received quadlet per cycle.
module phy_rx_pair
    import phy_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [QW-1:0] rx_quadlet,
    output logic          pkt_stb,
    output logic [QW-1:0] pkt_word
);
    logic          have_first;
    logic [QW-1:0] held;

    // Alternate between holding a first quadlet and consuming its partner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_first <= 1'b0;
            held       <= '0;
        end else if (rx_valid) begin
            if (!have_first) begin
                held       <= rx_quadlet;
                have_first <= 1'b1;
            end else begin
                have_first <= 1'b0;
            end
        end
    end

    assign pkt_stb  = rx_valid && have_first && (rx_quadlet == ~held);
    assign pkt_word = held;

    AST_STB_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_stb |=> !have_first); // R1
endmodule

// File: rtl/phy_port_state.sv
// Per-port enable and suspend bits plus a fault flag, changed by remote
// commands and resume. Assumes a command and a resume never coincide.
module phy_port_state
    import phy_ctl_pkg::*;
#(
    parameter int NPORTS = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic [3:0]        cmd_port,
    input  logic [2:0]        cmd_op,
    input  logic              resume_stb,
    input  logic              fault_set,
    output logic              cmd_bad,
    output logic [NPORTS-1:0] port_en,
    output logic [NPORTS-1:0] port_susp,
    output logic              fault
);
    logic cmd_ok;

    assign cmd_bad = (int'(cmd_port) >= NPORTS) || (cmd_op > OP_LAST);
    assign cmd_ok  = cmd_stb && !cmd_bad;

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        logic sel;
        assign sel = cmd_ok && (int'(cmd_port) == g);

        // Update the enable and suspend bits of one port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                port_en[g]   <= 1'b1;
                port_susp[g] <= 1'b0;
            end else begin
                if (resume_stb)
                    port_susp[g] <= 1'b0;
                if (sel) begin
                    case (cmd_op)
                        OP_PORT_OFF: port_en[g]   <= 1'b0;
                        OP_PORT_ON:  port_en[g]   <= 1'b1;
                        OP_SUSP_ON:  port_susp[g] <= 1'b1;
                        OP_SUSP_OFF: port_susp[g] <= 1'b0;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Sticky fault flag: set by the input, cleared by a legal clear command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault <= 1'b0;
        else if (fault_set)
            fault <= 1'b1;
        else if (cmd_ok && cmd_op == OP_CLR_FAULT)
            fault <= 1'b0;
    end

    AST_BAD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_bad && !fault_set) |=> ($stable(port_en) && $stable(port_susp) && $stable(fault))); // R7
    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        resume_stb |=> (port_susp == '0)); // R9
    AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_set |=> fault); // R13
endmodule

// File: rtl/phy_reply_tx.sv
// Sends up to MAXW reply words, each followed by its inverse, on a
// valid/ready stream. For a ping, bits [7:0] of word 0 carry the number of
// cycles that word was stalled. Assumes load is ignored while busy.
module phy_reply_tx
    import phy_ctl_pkg::*;
#(
    parameter int MAXW = 3
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [MAXW*QW-1:0]            words,
    input  logic [$clog2(MAXW+1)-1:0]     count,
    input  logic                          stamp,
    input  logic                          ready,
    output logic                          valid,
    output logic [QW-1:0]                 quadlet
);
    localparam int CW = $clog2(MAXW + 1);
    localparam int IW = (MAXW > 1) ? $clog2(MAXW) : 1;

    logic [QW-1:0] wbuf [MAXW];
    logic [CW-1:0] rem;
    logic [IW-1:0] idx;
    logic          phase;
    logic          stamp_q;
    logic [7:0]    wait_cnt;
    logic [QW-1:0] cur;

    // Load a reply, step through word/inverse pairs, count stall cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            rem      <= '0;
            idx      <= '0;
            phase    <= 1'b0;
            stamp_q  <= 1'b0;
            wait_cnt <= '0;
            for (int i = 0; i < MAXW; i++) wbuf[i] <= '0;
        end else if (load && !valid) begin
            for (int i = 0; i < MAXW; i++) wbuf[i] <= words[i*QW +: QW];
            rem      <= count;
            idx      <= '0;
            phase    <= 1'b0;
            stamp_q  <= stamp;
            wait_cnt <= '0;
            valid    <= 1'b1;
        end else if (valid) begin
            if (ready) begin
                if (!phase) begin
                    phase <= 1'b1;
                end else begin
                    phase <= 1'b0;
                    rem   <= rem - 1'b1;
                    if (rem == CW'(1))
                        valid <= 1'b0;
                    else
                        idx <= idx + 1'b1;
                end
            end else if (idx == '0 && !phase && wait_cnt != 8'hFF) begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

    // Current word, with the stall count placed into word 0 of a ping.
    always_comb begin
        cur = wbuf[idx];
        if (stamp_q && idx == '0)
            cur[7:0] = wait_cnt;
    end

    assign quadlet = phase ? ~cur : cur;

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> valid); // R10
    AST_INVERSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && !phase) |=> (valid && quadlet == ~$past(quadlet))); // R10
endmodule

// File: rtl/phy_ctl_responder.sv
// Top of the PHY control packet responder: validates packet pairs, matches
// the target node, updates link-on and port state, and queues one reply.
// Assumes the register file read port answers in the same cycle.
module phy_ctl_responder
    import phy_ctl_pkg::*;
#(
    parameter int NPORTS = 3,
    parameter int NSELF  = 3
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [5:0]            node_id,
    input  logic                  rx_valid,
    input  logic [31:0]           rx_quadlet,
    input  logic [NSELF*32-1:0]   selfid_words,
    output logic [3:0]            reg_addr,
    input  logic [7:0]            reg_data,
    input  logic                  fault_set,
    output logic                  reply_valid,
    input  logic                  reply_ready,
    output logic [31:0]           reply_quadlet,
    output logic                  link_on,
    output logic [NPORTS-1:0]     port_en,
    output logic [NPORTS-1:0]     port_susp,
    output logic                  fault,
    output logic [7:0]            drop_count
);
    localparam int CW = $clog2(NSELF + 1);

    logic          pkt_stb;
    logic [QW-1:0] pkt;
    logic          hit, is_ext;
    logic          is_ping, is_read, is_cmd, is_resume;
    logic          req, accept;
    logic          cmd_bad;
    logic [QW-1:0] one_word;
    logic [NSELF*QW-1:0] load_words;
    logic [CW-1:0] load_count;

    phy_rx_pair u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_quadlet (rx_quadlet),
        .pkt_stb    (pkt_stb),
        .pkt_word   (pkt)
    );

    assign hit       = pkt_stb && (pkt[29:24] == node_id) && (pkt[29:24] != NODE_BCAST);
    assign is_ext    = hit && (pkt[31:30] == KIND_EXT);
    assign is_ping   = is_ext && (pkt[21:18] == SUB_PING);
    assign is_read   = is_ext && (pkt[21:18] == SUB_READ);
    assign is_cmd    = is_ext && (pkt[21:18] == SUB_CMD);
    assign is_resume = is_ext && (pkt[21:18] == SUB_RESUME);
    assign req       = is_ping || is_read || is_cmd;
    assign accept    = req && !reply_valid;
    assign reg_addr  = pkt[17:14];

    phy_port_state #(.NPORTS(NPORTS)) u_ports (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_stb    (accept && is_cmd),
        .cmd_port   (pkt[17:14]),
        .cmd_op     (pkt[2:0]),
        .resume_stb (is_resume),
        .fault_set  (fault_set),
        .cmd_bad    (cmd_bad),
        .port_en    (port_en),
        .port_susp  (port_susp),
        .fault      (fault)
    );

    // Build the reply words for whichever request was accepted.
    always_comb begin
        if (is_read)
            one_word = {2'b00, node_id, 2'b00, SUB_RDREPLY, pkt[17:14], 6'd0, reg_data};
        else
            one_word = {2'b00, node_id, 2'b00, SUB_CONFIRM, pkt[17:14], 10'd0, cmd_bad, pkt[2:0]};
        load_words       = '0;
        load_words[31:0] = one_word;
        load_count       = CW'(1);
        if (is_ping) begin
            load_words = selfid_words;
            load_count = CW'(NSELF);
        end
    end

    phy_reply_tx #(.MAXW(NSELF)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .words   (load_words),
        .count   (load_count),
        .stamp   (is_ping),
        .ready   (reply_ready),
        .valid   (reply_valid),
        .quadlet (reply_quadlet)
    );

    // Sticky link-on flag for a matching link-on packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            link_on <= 1'b0;
        else if (hit && pkt[31:30] == KIND_LINK)
            link_on <= 1'b1;
    end

    // Saturating count of requests refused while a reply is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drop_count <= '0;
        else if (req && reply_valid && drop_count != 8'hFF)
            drop_count <= drop_count + 1'b1;
    end

    AST_LINK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        link_on |=> link_on); // R3
    AST_NO_BCAST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_on) |-> ($past(node_id) != NODE_BCAST)); // R2
    AST_DROP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !reply_valid |=> $stable(drop_count)); // R11
endmodule

// File: tb/phy_ctl_responder_test.sv
// Sweeping self-checking bench for phy_ctl_responder (3 ports, 3 self-ID words).
module phy_ctl_responder_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;
    localparam int NS = 3;
    localparam logic [5:0] ME = 6'd21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] node_id = ME;
    logic rx_valid = 1'b0;
    logic [31:0] rx_quadlet = '0;
    logic [NS*32-1:0] selfid_words;
    logic [3:0] reg_addr;
    logic [7:0] reg_data;
    logic fault_set = 1'b0;
    logic reply_valid;
    logic reply_ready = 1'b1;
    logic [31:0] reply_quadlet;
    logic link_on;
    logic [NP-1:0] port_en, port_susp;
    logic fault;
    logic [7:0] drop_count;

    int tests = 0;
    int fails = 0;
    logic [NP-1:0] m_en = '1;
    logic [NP-1:0] m_sus = '0;
    logic m_flt = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] sw(int i);
        return 32'h8000_2460 + i * 32'h0040_0011;
    endfunction

    for (genvar g = 0; g < NS; g++) begin : g_sw
        assign selfid_words[g*32 +: 32] = sw(g);
    end
    assign reg_data = {~reg_addr, reg_addr};

    phy_ctl_responder #(.NPORTS(NP), .NSELF(NS)) uut (
        .clk(clk), .rst_n(rst_n), .node_id(node_id), .rx_valid(rx_valid),
        .rx_quadlet(rx_quadlet), .selfid_words(selfid_words), .reg_addr(reg_addr),
        .reg_data(reg_data), .fault_set(fault_set), .reply_valid(reply_valid),
        .reply_ready(reply_ready), .reply_quadlet(reply_quadlet), .link_on(link_on),
        .port_en(port_en), .port_susp(port_susp), .fault(fault), .drop_count(drop_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lnk(logic [5:0] t);
        return {2'b01, t, 24'h0};
    endfunction

    function automatic logic [31:0] ext(logic [5:0] t, logic [3:0] sub, logic [3:0] idx, logic [2:0] op);
        return {2'b00, t, 2'b00, sub, idx, 11'h0, op};
    endfunction

    // Drive a quadlet and its partner; leaves the bench one negedge after the processing edge.
    task automatic send(input logic [31:0] q, input bit corrupt);
        rx_valid = 1'b1;
        rx_quadlet = q;
        @(negedge clk);
        rx_quadlet = corrupt ? (~q ^ 32'h1) : ~q;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Expect one word followed by its inverse, with ready held high.
    task automatic recv(input string req, input logic [31:0] exp);
        chk(req, {31'd0, reply_valid}, 32'd1);
        chk(req, reply_quadlet, exp);
        @(negedge clk);
        chk(req, {31'd0, reply_valid}, 32'd1);
        chk(req, reply_quadlet, ~exp);
        @(negedge clk);
    endtask

    task automatic chk_state(input string req);
        chk(req, 32'(port_en), 32'(m_en));
        chk(req, 32'(port_susp), 32'(m_sus));
        chk(req, {31'd0, fault}, {31'd0, m_flt});
    endtask

    task automatic command(input logic [3:0] p, input logic [2:0] o);
        logic bad;
        bad = (p >= NP) || (o > 3'd4);
        send(ext(ME, 4'd8, p, o), 1'b0);
        if (!bad) begin
            case (o)
                3'd0: m_en[p[1:0]] = 1'b0;
                3'd1: m_en[p[1:0]] = 1'b1;
                3'd2: m_sus[p[1:0]] = 1'b1;
                3'd3: m_sus[p[1:0]] = 1'b0;
                default: m_flt = 1'b0;
            endcase
        end
        chk_state(bad ? "R7 state" : "R6 state");
        recv(bad ? "R7 confirm" : "R8 confirm", {2'b00, ME, 2'b00, 4'd10, p, 10'd0, bad, o});
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 valid", {31'd0, reply_valid}, 32'd0);
        chk("R12 link", {31'd0, link_on}, 32'd0);
        chk("R12 drops", 32'(drop_count), 32'd0);
        chk_state("R12 ports");

        // R2 link-on targets that must not match
        for (int t = 0; t < 64; t++) begin
            if (t != ME) begin
                send(lnk(6'(t)), 1'b0);
                chk("R2 link miss", {31'd0, link_on}, 32'd0);
            end
        end
        node_id = 6'd63;
        send(lnk(6'd63), 1'b0);
        chk("R2 broadcast", {31'd0, link_on}, 32'd0);
        node_id = ME;

        // R1 corrupted pairs are discarded
        send(lnk(ME), 1'b1);
        chk("R1 bad link", {31'd0, link_on}, 32'd0);
        send(ext(ME, 4'd0, 4'd0, 3'd0), 1'b1);
        chk("R1 bad ping", {31'd0, reply_valid}, 32'd0);

        // R3 matching link-on is sticky
        send(lnk(ME), 1'b0);
        chk("R3 link set", {31'd0, link_on}, 32'd1);
        send(lnk(6'd5), 1'b0);
        chk("R3 link stays", {31'd0, link_on}, 32'd1);

        // R4 ping without stall, then misaddressed ping
        send(ext(ME, 4'd0, 4'd0, 3'd0), 1'b0);
        for (int i = 0; i < NS; i++)
            recv("R4 ping", (i == 0) ? {sw(0)[31:8], 8'd0} : sw(i));
        chk("R4 ping end", {31'd0, reply_valid}, 32'd0);
        send(ext(6'd22, 4'd0, 4'd0, 3'd0), 1'b0);
        chk("R2 ping miss", {31'd0, reply_valid}, 32'd0);

        // R4 stalled pings: 5 cycles and a saturating 300
        for (int s = 0; s < 2; s++) begin
            int k;
            k = (s == 0) ? 5 : 300;
            reply_ready = 1'b0;
            send(ext(ME, 4'd0, 4'd0, 3'd0), 1'b0);
            for (int c = 0; c < k; c++) @(negedge clk);
            chk("R10 held", {31'd0, reply_valid}, 32'd1);
            reply_ready = 1'b1;
            for (int i = 0; i < NS; i++)
                recv("R4 stall", (i == 0) ? {sw(0)[31:8], 8'((k > 255) ? 255 : k)} : sw(i));
        end

        // R5 register read sweep
        for (int a = 0; a < 16; a++) begin
            send(ext(ME, 4'd1, 4'(a), 3'd0), 1'b0);
            recv("R5 read", {2'b00, ME, 2'b00, 4'd3, 4'(a), 6'd0, ~4'(a), 4'(a)});
        end

        // R6/R7/R8/R13 command sweep over all ports and operations
        for (int p = 0; p < 16; p++) begin
            for (int o = 0; o < 8; o++) begin
                if (o == 4) begin
                    fault_set = 1'b1;
                    @(negedge clk);
                    fault_set = 1'b0;
                    m_flt = 1'b1;
                    chk("R13 fault set", {31'd0, fault}, 32'd1);
                end
                command(4'(p), 3'(o));
            end
        end

        // R9/R11 resume during a pending reply, dropped command
        command(4'd0, 3'd2);
        command(4'd2, 3'd2);
        reply_ready = 1'b0;
        send(ext(ME, 4'd1, 4'd7, 3'd0), 1'b0);
        send(ext(ME, 4'd8, 4'd1, 3'd0), 1'b0);
        chk("R11 drop count", 32'(drop_count), 32'd1);
        send(ext(ME, 4'd15, 4'd0, 3'd0), 1'b0);
        m_sus = '0;
        chk_state("R9 R11 state");
        reply_ready = 1'b1;
        recv("R11 pending reply", {2'b00, ME, 2'b00, 4'd3, 4'd7, 6'd0, 8'h87});
        chk("R9 no resume reply", {31'd0, reply_valid}, 32'd0);

        // R11 drop counter saturates
        reply_ready = 1'b0;
        send(ext(ME, 4'd1, 4'd2, 3'd0), 1'b0);
        for (int n = 0; n < 260; n++) send(ext(ME, 4'd0, 4'd0, 3'd0), 1'b0);
        chk("R11 saturate", 32'(drop_count), 32'd255);
        reply_ready = 1'b1;
        recv("R11 drain", {2'b00, ME, 2'b00, 4'd3, 4'd2, 6'd0, 8'hD2});
        chk("R11 idle", {31'd0, reply_valid}, 32'd0);

        finish_run();
    end
endmodule